// File: doc/BRIEF.md
# DDS Control Word Loader

This block is the host-side loader of a direct digital synthesis core. A host builds a 40-bit control word, made of a 32-bit tuning word and an 8-bit control byte, in a staging register. It can send the word as five bytes on a byte-wide bus or as forty single bits on a serial pin. Each byte or bit is marked by a one-cycle load strobe.

A separate commit strobe copies the staging register into the active register in one step. The core therefore never sees a half-written word. The active register drives the tuning word, the phase offset and the power-down flag. It also holds the format field, which picks whether later load strobes take a byte or a bit.

All inputs are synchronous to `clk`. Reset returns the block to byte mode, with both registers cleared.

Top module: `dds_word_loader`

## Requirements
- R1: After reset, `tune_word`, `phase_off` and `pwr_down` are zero and `ser_mode` is 0.
- R2: In byte mode, the first load strobe after reset or after a commit writes the control byte (word bits 39:32). The next four strobes write the tuning word from its most significant byte (bits 31:24) down to its least significant byte (bits 7:0).
- R3: The control byte holds the phase offset in bits 7:3, the power-down flag in bit 2 and the format field in bits 1:0. A committed format of 2'b01 selects serial mode. Any other value selects byte mode.
- R4: In serial mode, the n-th strobe after reset or a commit writes `ser_din` into word bit n-1, so bits 0..31 form the tuning word and bits 32..39 form the control byte. `data_in` is ignored in this mode, and `ser_din` is ignored in byte mode.
- R5: The outputs change only in the cycle after a commit strobe. They then show the staging content as it stood before that commit edge.
- R6: A sixth byte strobe without a commit wraps back and overwrites the control byte.
- R7: A 41st serial strobe without a commit wraps back and overwrites bit 0.
- R8: A commit restarts the byte and bit sequences, so the next load strobe addresses the first position again.
- R9: A format change written into the staging register has no effect on how loads are taken until it is committed.
- R10: When a load strobe and a commit strobe coincide, the active register receives the staging content without that load. The load still lands in staging at its current position, and the next strobe addresses the first position.
- R11: A commit leaves the staging register unchanged, so positions not rewritten afterwards keep their old content for the next commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_stb | input | 1 | One-cycle strobe taking one byte or one bit |
| data_in | input | 8 | Byte for byte-mode loads |
| ser_din | input | 1 | Bit for serial-mode loads |
| commit_stb | input | 1 | One-cycle strobe copying staging to active |
| tune_word | output | 32 | Active tuning word |
| phase_off | output | 5 | Active phase offset |
| pwr_down | output | 1 | Active power-down flag |
| ser_mode | output | 1 | 1 when the committed format selects serial loading |

## Verification
A load strobe and a commit strobe can fall in the same cycle. The commit then has to pick up the old staging word, the load must still land at its slot, and the sequence must restart. The bench raises both strobes together partway through a byte load and again during a serial load. It then compares the outputs with a bench model that applies the commit to the staging word as it stood before the edge. A following commit shows where the coinciding load landed and where the next load started.

// File: rtl/dds_ldr_pkg.sv
// Shared constants and control-byte layout for the DDS word loader.
// Assumes a byte-sized control field at the top of the word.
package dds_ldr_pkg;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = 5;
    localparam int WORD_W  = BYTE_W * N_BYTES;
    localparam int TUNE_W  = WORD_W - BYTE_W;
    localparam int PHASE_W = 5;
    localparam int FMT_W   = 2;

    localparam logic [FMT_W-1:0] FMT_SERIAL = 2'b01;

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic               pd;
        logic [FMT_W-1:0]   fmt;
    } ctrl_t;
endpackage

// File: rtl/dds_step_counter.sv
// Position counter that wraps after LIMIT steps.
// Assumes clr has priority over adv, and that reset is synchronous.
module dds_step_counter #(
    parameter int LIMIT = 5,
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          clr,
    output logic [CW-1:0] idx
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    // Advance, wrap or restart the position.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   idx <= '0;
        else if (adv)        idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end

    assert_in_range_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= LAST);
    assert_wrap_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && idx == LAST) |=> idx == '0);
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> idx == '0);
endmodule

// File: rtl/dds_word_regs.sv
// Staging and active word registers.
// Byte writes fill lane (N_BYTES-1-slot), so slot 0 is the top byte.
// Bit writes fill bit ser_idx. Assumes at most one write enable per cycle.
module dds_word_regs #(
    parameter int BYTE_W  = 8,
    parameter int N_BYTES = 5,
    localparam int WORD_W = BYTE_W * N_BYTES,
    localparam int YW     = (N_BYTES > 1) ? $clog2(N_BYTES) : 1,
    localparam int BW     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_we,
    input  logic [YW-1:0]     par_idx,
    input  logic [BYTE_W-1:0] par_byte,
    input  logic              ser_we,
    input  logic [BW-1:0]     ser_idx,
    input  logic              ser_bit,
    input  logic              upd,
    output logic [WORD_W-1:0] active_q
);
    logic [WORD_W-1:0] stage_q;
    logic [WORD_W-1:0] stage_d;

    for (genvar j = 0; j < WORD_W; j++) begin : g_bit
        localparam int LANE = j / BYTE_W;
        localparam int SLOT = N_BYTES - 1 - LANE;
        logic par_hit, ser_hit;
        assign par_hit = par_we && (par_idx == YW'(SLOT));
        assign ser_hit = ser_we && (ser_idx == BW'(j));
        assign stage_d[j] = par_hit ? par_byte[j % BYTE_W] :
                            ser_hit ? ser_bit : stage_q[j];
    end

    // Staging register takes the addressed byte or bit.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    // Active register copies staging as it stood before the commit edge.
    always_ff @(posedge clk) begin
        if (!rst_n)   active_q <= '0;
        else if (upd) active_q <= stage_q;
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(active_q));
    assert_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> active_q == $past(stage_q));
    assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !par_we && !ser_we) |=> $stable(stage_q));
    assert_one_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({par_we, ser_we}));
endmodule

// File: rtl/dds_word_loader.sv
// Top of the DDS control word loader.
// Routes load strobes to the byte or bit path, based on the committed format.
// A commit restarts both sequences. Assumes all strobes are synchronous one-cycle pulses.
module dds_word_loader
    import dds_ldr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_stb,
    input  logic [BYTE_W-1:0]  data_in,
    input  logic               ser_din,
    input  logic               commit_stb,
    output logic [TUNE_W-1:0]  tune_word,
    output logic [PHASE_W-1:0] phase_off,
    output logic               pwr_down,
    output logic               ser_mode
);
    localparam int YW = $clog2(N_BYTES);
    localparam int BW = $clog2(WORD_W);

    logic              par_we, ser_we;
    logic [YW-1:0]     byte_idx;
    logic [BW-1:0]     bit_idx;
    logic [WORD_W-1:0] active;
    ctrl_t             ctrl;

    assign par_we = load_stb && !ser_mode;
    assign ser_we = load_stb &&  ser_mode;

    dds_step_counter #(.LIMIT(N_BYTES)) i_byte_seq (
        .clk(clk), .rst_n(rst_n), .adv(par_we), .clr(commit_stb), .idx(byte_idx)
    );

    dds_step_counter #(.LIMIT(WORD_W)) i_bit_seq (
        .clk(clk), .rst_n(rst_n), .adv(ser_we), .clr(commit_stb), .idx(bit_idx)
    );

    dds_word_regs #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .par_we(par_we), .par_idx(byte_idx), .par_byte(data_in),
        .ser_we(ser_we), .ser_idx(bit_idx), .ser_bit(ser_din),
        .upd(commit_stb), .active_q(active)
    );

    // Split the active word into the fields the core uses.
    always_comb begin
        ctrl      = ctrl_t'(active[WORD_W-1:TUNE_W]);
        tune_word = active[TUNE_W-1:0];
        phase_off = ctrl.phase;
        pwr_down  = ctrl.pd;
        ser_mode  = (ctrl.fmt == FMT_SERIAL);
    end

    assert_mode_on_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_stb |=> $stable(ser_mode));
    assert_outputs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_stb |=> $stable({tune_word, phase_off, pwr_down}));
endmodule

// File: tb/test_dds_word_loader.sv
`timescale 1ns/1ps
module test_dds_word_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_stb = 1'b0;
    logic [7:0]  data_in = '0;
    logic        ser_din = 1'b0;
    logic        commit_stb = 1'b0;
    logic [31:0] tune_word;
    logic [4:0]  phase_off;
    logic        pwr_down;
    logic        ser_mode;

    int total = 0;
    int bad = 0;

    // Bench model of the requirements
    logic [39:0] m_stage = '0;
    logic [39:0] m_act = '0;
    int          m_bidx = 0;
    int          m_sidx = 0;
    logic        m_ser = 1'b0;

    always #5 clk = ~clk;

    dds_word_loader i_dds_word_loader (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .data_in(data_in),
        .ser_din(ser_din), .commit_stb(commit_stb), .tune_word(tune_word),
        .phase_off(phase_off), .pwr_down(pwr_down), .ser_mode(ser_mode)
    );

    task automatic check(input string req);
        logic [38:0] act, exp;
        act = {phase_off, pwr_down, ser_mode, tune_word};
        exp = {m_act[39:35], m_act[34], (m_act[33:32] == 2'b01), m_act[31:0]};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle with optional load and commit. The model follows R2, R4 and R6 to R11.
    task automatic cyc(input logic w, input logic [7:0] d, input logic b, input logic u);
        logic [39:0] old;
        @(negedge clk);
        load_stb = w; data_in = d; ser_din = b; commit_stb = u;
        @(negedge clk);
        load_stb = 0; commit_stb = 0; data_in = 8'h5a; ser_din = 1'b1;
        old = m_stage;
        if (w) begin
            if (!m_ser) begin
                m_stage[(4 - m_bidx)*8 +: 8] = d;
                m_bidx = (m_bidx == 4) ? 0 : m_bidx + 1;
            end else begin
                m_stage[m_sidx] = b;
                m_sidx = (m_sidx == 39) ? 0 : m_sidx + 1;
            end
        end
        if (u) begin
            m_act = old; m_bidx = 0; m_sidx = 0;
            m_ser = (m_act[33:32] == 2'b01);
        end
    endtask

    task automatic send_bytes(input logic [39:0] w);
        for (int i = 0; i < 5; i++) cyc(1'b1, w[(4-i)*8 +: 8], ~w[0], 1'b0);
    endtask

    task automatic send_bits(input logic [39:0] w, input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 8'(i * 37), w[i % 40], 1'b0);
    endtask

    task automatic commit();
        cyc(1'b0, 8'hc3, 1'b1, 1'b1);
    endtask

    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [39:0] w;
        logic [1:0]  f;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state");

        // R2 R3 R5: sweep every phase value, both power-down values, non-serial formats
        for (int p = 0; p < 32; p++) begin
            f = (p % 3 == 0) ? 2'b00 : (p % 3 == 1) ? 2'b10 : 2'b11;
            w = {5'(p), 1'(p % 2), f, 32'(32'h9e3779b9 * (p + 1))};
            send_bytes(w);
            check("R5 outputs held before commit");
            commit();
            check("R2 R3 byte load committed");
        end

        // R6: sixth byte wraps onto the control byte
        send_bytes(40'h13_a1b2c3d4);
        cyc(1'b1, 8'hf4, 1'b0, 1'b0);
        commit();
        check("R6 byte wrap");

        // R8 R11: partial load then commit, then fresh sequence
        cyc(1'b1, 8'h2c, 1'b0, 1'b0);
        cyc(1'b1, 8'h77, 1'b0, 1'b0);
        commit();
        check("R11 partial load keeps old bytes");
        send_bytes(40'h88_01020304);
        commit();
        check("R8 sequence restarts after commit");

        // R10: load and commit in one cycle during a byte load
        cyc(1'b1, 8'h41, 1'b0, 1'b0);
        cyc(1'b1, 8'h99, 1'b0, 1'b1);
        check("R10 coincident commit takes pre-load word");
        cyc(1'b1, 8'h30, 1'b0, 1'b0);
        commit();
        check("R10 coincident load landed, sequence restarted");

        // R9: serial format staged but not committed keeps byte mode
        cyc(1'b1, 8'h51, 1'b0, 1'b0);
        cyc(1'b1, 8'hde, 1'b0, 1'b0);
        check("R9 mode unchanged before commit");
        cyc(1'b1, 8'had, 1'b0, 1'b0);
        cyc(1'b1, 8'hbe, 1'b0, 1'b0);
        cyc(1'b1, 8'hef, 1'b0, 1'b0);
        commit();
        check("R9 serial mode after commit");

        // R4: serial sweep, LSB first, data_in driven with noise
        for (int k = 0; k < 12; k++) begin
            w = {5'(k * 7), 1'(k % 2), 2'b01, 32'(32'h7f4a7c15 * (k + 3))};
            send_bits(w, 40);
            check("R5 serial outputs held before commit");
            commit();
            check("R4 serial load committed");
        end

        // R7: 41st bit wraps onto bit 0
        w = {5'd9, 1'b0, 2'b01, 32'h0000_0010};
        send_bits(w, 40);
        cyc(1'b1, 8'h00, 1'b1, 1'b0);
        commit();
        check("R7 bit wrap");

        // R10 in serial mode
        send_bits({8'h21, 32'hffff_0000}, 5);
        cyc(1'b1, 8'h00, 1'b1, 1'b1);
        check("R10 serial coincident commit");
        send_bits({8'h21, 32'hffff_0000}, 3);
        commit();
        check("R10 serial load landed, restart");

        // R3 R4: serial word selecting byte format returns to byte mode; ser_din ignored
        send_bits({5'd3, 1'b1, 2'b10, 32'hcafe_f00d}, 40);
        commit();
        check("R3 back to byte mode");
        send_bytes(40'hf8_12345678);
        commit();
        check("R4 byte load after serial");

        // R1: reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_stage = '0; m_act = '0; m_bidx = 0; m_sidx = 0; m_ser = 1'b0;
        @(negedge clk);
        check("R1 reset after use");
        commit();
        check("R1 staging cleared by reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule